// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Status Registers

This block is the register front of a byte-wide serial port in the classic eight-register layout. It works out which interrupt source the host should service first and drives a single level interrupt line from that result. It returns the identification byte, the line status byte and the modem status byte, and applies the side effects that reading them has. It also holds the receive buffer that feeds the data port, the interrupt enable mask, the divisor latch, and line, modem-control and scratch storage. A transmitted byte leaves on the `tx_valid`/`tx_byte` strobe in the cycle after the write, so the transmitter always reports itself as ready. No serial shifter or bit timing is modelled.

The host makes one access per cycle through `bus_valid`/`bus_write`/`bus_addr`. Read data is combinational and valid in the strobe cycle. Every side effect of an access takes hold at the clock edge that closes that cycle. The interrupt line is a function of the registered state, so it reflects each access from the next cycle on. Received bytes arrive on `rx_valid`/`rx_byte`. The four modem input lines arrive on `modem_in` and are sampled every cycle.

Parameters: `FIFO_DEPTH` (a power of two, at least 2; default 16), `ADDR_W` (at least 3; default 4), `REF_CLK_HZ` and `BAUD`. The reset divisor is REF_CLK_HZ / BAUD / 16, which is 12 with the defaults.

Top module: `uart_iid_top`

## Requirements
- R1: The pending cause is chosen in this order, with these identification codes in bits 3:0: overrun pending with enable bit 2 set (0x6); receive buffer non-empty with enable bit 0 set (0xC); transmit-empty pending with enable bit 1 set (0x2); any modem delta with enable bit 3 set (0x0); otherwise none (0x1). The identification byte is read at offset 2.
- R2: `irq` is high exactly when the pending cause is not "none". It follows every access from the cycle after that access.
- R3: A write to offset 1 (with bit 7 of the line control byte at offset 3 clear) keeps only bits 3:0. A read returns zeros in bits 7:4.
- R4: A write to offset 0 (with bit 7 of the line control byte clear) pulses `tx_valid` with that byte in the next cycle. It also sets a sticky transmit-empty pending flag.
- R5: An identification read that reports code 0x2 clears the transmit-empty pending flag. A read that reports any other code leaves the flag set.
- R6: The identification byte has bits 7:6 set to 11 while the FIFO is enabled and 00 while it is disabled.
- R7: The line status byte at offset 5 always has bits 6 and 5 set. Bit 0 is 1 exactly when the receive buffer holds data. Bit 1 is the overrun flag, which is cleared after it has been read. Writes to offset 5 have no effect.
- R8: The receive buffer holds 1 byte while the FIFO is disabled and FIFO_DEPTH bytes while it is enabled. A byte that arrives when the buffer is at capacity is dropped and sets overrun. Reads of offset 0 return bytes in arrival order, or 0xFF when the buffer is empty.
- R9: A write to offset 2 sets the FIFO enable from bit 0. The receive buffer is emptied when the enable changes, or when bit 1 is written together with bit 0.
- R10: While bit 7 of the line control byte is set, offsets 0 and 1 access the low and high divisor bytes (reset values 12 and 0). Data writes in this mode transmit nothing.
- R11: `modem_in` bits are CTS=0, DSR=1, RI=2, DCD=3. The byte at offset 6 returns the sampled lines in bits 7:4 (DCD, RI, DSR, CTS) and delta flags in bits 3:0. Bit 3 is DCD changed, bit 2 is RI fell, bit 1 is DSR changed and bit 0 is CTS changed. The deltas are sticky, they are cleared by reading offset 6, and writes to offset 6 have no effect.
- R12: Offsets 7 and below hold the registers listed above (offset 4 keeps 5 bits, offset 7 is an 8-bit scratch byte). Reads at offsets 8 and above return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| modem_in | input | 4 | Modem lines: CTS, DSR, RI, DCD |
| tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest state to reach is the one where several causes are pending at the same time and an identification read must leave a lower-ranked transmit-empty flag untouched. The stimulus writes a data byte, delivers a received byte and toggles a modem line with every enable set. It then reads the identification byte repeatedly, removing the top cause with its own side-effecting read each time, so that each lower cause surfaces in turn. Overrun is reached at both capacities: by sending a second byte with the FIFO disabled, and by sending one byte past FIFO_DEPTH with it enabled.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  typedef enum logic [3:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_TX    = 4'h2,
    CAUSE_LINE  = 4'h6,
    CAUSE_RXTO  = 4'hC
  } cause_t;

  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_IEN     = 3'd1;
  localparam logic [2:0] OFS_IID     = 3'd2;
  localparam logic [2:0] OFS_LCTL    = 3'd3;
  localparam logic [2:0] OFS_MCTL    = 3'd4;
  localparam logic [2:0] OFS_LSTAT   = 3'd5;
  localparam logic [2:0] OFS_MSTAT   = 3'd6;
  localparam logic [2:0] OFS_SCRATCH = 3'd7;

  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;

  // Request vector slot order is the service order: slot 0 highest.
  function automatic cause_t pick_cause(input logic [3:0] hit);
    cause_t c;
    c = CAUSE_NONE;
    for (int i = 3; i >= 0; i--) begin
      if (hit[i]) begin
        case (i)
          0:       c = CAUSE_LINE;
          1:       c = CAUSE_RXTO;
          2:       c = CAUSE_TX;
          default: c = CAUSE_MODEM;
        endcase
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] iid_byte(input logic fifo_on, input cause_t c);
    return {fifo_on, fifo_on, 2'b00, c};
  endfunction

  function automatic logic [7:0] lstat_byte(input logic have_data, input logic overrun);
    return {1'b0, 1'b1, 1'b1, 3'b000, overrun, have_data};
  endfunction

  // lines: [0] CTS, [1] DSR, [2] RI, [3] DCD
  function automatic logic [3:0] line_deltas(input logic [3:0] was, input logic [3:0] now);
    return {was[3] ^ now[3], was[2] & ~now[2], was[1] ^ now[1], was[0] ^ now[0]};
  endfunction

endpackage

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
(
  input  logic [3:0] ien,
  input  logic       overrun,
  input  logic       rx_any,
  input  logic       tx_pend,
  input  logic       modem_any,
  output logic [3:0] hit,
  output cause_t     cause
);

  logic [3:0] req;

  assign req = {modem_any & ien[IEN_MODEM],
                tx_pend   & ien[IEN_TX],
                rx_any    & ien[IEN_RX],
                overrun   & ien[IEN_LINE]};

  // isolate the lowest set slot, which is the highest-ranked request
  assign hit   = req & (~req + 4'd1);
  assign cause = pick_cause(hit);

endmodule

// File: rtl/uart_iid_rxbuf.sv
module uart_iid_rxbuf #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cap;
  logic             at_cap, do_push, do_pop;

  assign cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign at_cap  = count >= cap;
  assign do_push = push & ~at_cap & ~flush;
  assign do_pop  = pop & (count != '0) & ~flush;
  assign ovf     = push & at_cap & ~flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/uart_iid_modem.sv
module uart_iid_modem
  import uart_iid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lines_in,
  input  logic       clr,
  output logic [3:0] lines_q,
  output logic [3:0] delta_q,
  output logic       any_delta
);

  logic [3:0] fresh;

  assign fresh     = line_deltas(lines_q, lines_in);
  assign any_delta = delta_q != 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q <= 4'h0;
      delta_q <= 4'h0;
    end else begin
      lines_q <= lines_in;
      delta_q <= (clr ? 4'h0 : delta_q) | fresh;
    end
  end

endmodule

// File: rtl/uart_iid_top.sv
module uart_iid_top
  import uart_iid_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 4,
  parameter int REF_CLK_HZ = 1843200,
  parameter int BAUD       = 9600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [3:0]        modem_in,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);

  localparam int          CNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam int          DIV_INIT = REF_CLK_HZ / BAUD / 16;
  localparam logic [15:0] DIV_RST  = 16'(DIV_INIT);

  // register state
  logic [3:0] ien;
  logic [7:0] lctl;
  logic [4:0] mctl;
  logic [7:0] scratch;
  logic [7:0] div_lo, div_hi;
  logic       fifo_en;
  logic       thre_pend;
  logic       overrun;

  // decode
  logic       acc_rd, acc_wr, in_map, dlab;
  logic [2:0] off;

  assign acc_rd = bus_valid & ~bus_write;
  assign acc_wr = bus_valid &  bus_write;
  assign in_map = (bus_addr >> 3) == '0;
  assign off    = bus_addr[2:0];
  assign dlab   = lctl[7];

  // named access events
  logic ev_wr_data, ev_wr_ien, ev_wr_dll, ev_wr_dlh, ev_wr_fctl;
  logic ev_wr_lctl, ev_wr_mctl, ev_wr_scr;
  logic ev_rd_data, ev_rd_iid, ev_rd_lstat, ev_rd_mstat;

  assign ev_wr_data  = acc_wr & in_map & (off == OFS_DATA) & ~dlab;
  assign ev_wr_ien   = acc_wr & in_map & (off == OFS_IEN)  & ~dlab;
  assign ev_wr_dll   = acc_wr & in_map & (off == OFS_DATA) &  dlab;
  assign ev_wr_dlh   = acc_wr & in_map & (off == OFS_IEN)  &  dlab;
  assign ev_wr_fctl  = acc_wr & in_map & (off == OFS_IID);
  assign ev_wr_lctl  = acc_wr & in_map & (off == OFS_LCTL);
  assign ev_wr_mctl  = acc_wr & in_map & (off == OFS_MCTL);
  assign ev_wr_scr   = acc_wr & in_map & (off == OFS_SCRATCH);
  assign ev_rd_data  = acc_rd & in_map & (off == OFS_DATA) & ~dlab;
  assign ev_rd_iid   = acc_rd & in_map & (off == OFS_IID);
  assign ev_rd_lstat = acc_rd & in_map & (off == OFS_LSTAT);
  assign ev_rd_mstat = acc_rd & in_map & (off == OFS_MSTAT);

  // FIFO control: an enable change or a receive reset empties the buffer
  logic fifo_flush;
  assign fifo_flush = ev_wr_fctl &
                      ((bus_wdata[0] != fifo_en) | (bus_wdata[0] & bus_wdata[1]));

  // receive buffer
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             ovf_ev, rx_any;

  uart_iid_rxbuf #(.DEPTH(FIFO_DEPTH)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .flush     (fifo_flush),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (ev_rd_data),
    .head      (rx_head),
    .count     (rx_count),
    .ovf       (ovf_ev)
  );

  assign rx_any = rx_count != '0;

  // modem line tracking
  logic [3:0] mdm_lines, mdm_delta;
  logic       mdm_any;

  uart_iid_modem u_modem (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_in  (modem_in),
    .clr       (ev_rd_mstat),
    .lines_q   (mdm_lines),
    .delta_q   (mdm_delta),
    .any_delta (mdm_any)
  );

  // cause selection
  logic [3:0] hit;
  cause_t     cause;
  logic       tx_cause_read;

  uart_iid_prio u_prio (
    .ien       (ien),
    .overrun   (overrun),
    .rx_any    (rx_any),
    .tx_pend   (thre_pend),
    .modem_any (mdm_any),
    .hit       (hit),
    .cause     (cause)
  );

  assign tx_cause_read = ev_rd_iid & (cause == CAUSE_TX);
  assign irq           = cause != CAUSE_NONE;

  // register updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien       <= 4'h0;
      lctl      <= 8'h00;
      mctl      <= 5'h00;
      scratch   <= 8'h00;
      div_lo    <= DIV_RST[7:0];
      div_hi    <= DIV_RST[15:8];
      fifo_en   <= 1'b0;
      thre_pend <= 1'b0;
      overrun   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= 8'h00;
    end else begin
      tx_valid <= ev_wr_data;
      if (ev_wr_data) tx_byte <= bus_wdata;
      if (ev_wr_ien)  ien     <= bus_wdata[3:0];
      if (ev_wr_dll)  div_lo  <= bus_wdata;
      if (ev_wr_dlh)  div_hi  <= bus_wdata;
      if (ev_wr_fctl) fifo_en <= bus_wdata[0];
      if (ev_wr_lctl) lctl    <= bus_wdata;
      if (ev_wr_mctl) mctl    <= bus_wdata[4:0];
      if (ev_wr_scr)  scratch <= bus_wdata;

      if (ev_wr_data)         thre_pend <= 1'b1;
      else if (tx_cause_read) thre_pend <= 1'b0;

      if (ovf_ev)           overrun <= 1'b1;
      else if (ev_rd_lstat) overrun <= 1'b0;
    end
  end

  // read data
  always_comb begin
    bus_rdata = 8'hFF;
    if (in_map) begin
      case (off)
        OFS_DATA:    bus_rdata = dlab ? div_lo : (rx_any ? rx_head : 8'hFF);
        OFS_IEN:     bus_rdata = dlab ? div_hi : {4'h0, ien};
        OFS_IID:     bus_rdata = iid_byte(fifo_en, cause);
        OFS_LCTL:    bus_rdata = lctl;
        OFS_MCTL:    bus_rdata = {3'b000, mctl};
        OFS_LSTAT:   bus_rdata = lstat_byte(rx_any, overrun);
        OFS_MSTAT:   bus_rdata = {mdm_lines[3], mdm_lines[2], mdm_lines[1], mdm_lines[0], mdm_delta};
        default:     bus_rdata = scratch;
      endcase
    end
  end

endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk
  import uart_iid_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ien,
  input logic             overrun,
  input logic             irq,
  input cause_t           cause,
  input logic [3:0]       hit,
  input logic             ev_wr_data,
  input logic             ev_wr_ien,
  input logic             ev_wr_dll,
  input logic             ev_rd_iid,
  input logic             ev_rd_lstat,
  input logic             ovf_ev,
  input logic             thre_pend,
  input logic             tx_valid,
  input logic             fifo_en,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       bus_wdata
);

  // R1
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R2
  line_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && ien[IEN_LINE]) |-> (irq && cause == CAUSE_LINE));

  // R3
  ien_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ien |=> (ien == $past(bus_wdata[3:0])));

  // R4
  thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_data |=> (thre_pend && tx_valid));

  // R5
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_iid && cause == CAUSE_TX) |=> !thre_pend);

  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_lstat && !ovf_ev) |=> !overrun);

  // R8
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (rx_count <= CNT_W'(1)));

  // R10
  latch_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_dll |=> !tx_valid);

endmodule

bind uart_iid_top uart_iid_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ien         (ien),
  .overrun     (overrun),
  .irq         (irq),
  .cause       (cause),
  .hit         (hit),
  .ev_wr_data  (ev_wr_data),
  .ev_wr_ien   (ev_wr_ien),
  .ev_wr_dll   (ev_wr_dll),
  .ev_rd_iid   (ev_rd_iid),
  .ev_rd_lstat (ev_rd_lstat),
  .ovf_ev      (ovf_ev),
  .thre_pend   (thre_pend),
  .tx_valid    (tx_valid),
  .fifo_en     (fifo_en),
  .rx_count    (rx_count),
  .bus_wdata   (bus_wdata)
);

// File: tb/tb_uart_iid_top.sv
`timescale 1ns/1ps
module tb_uart_iid_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [3:0] modem_in = 4'h0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_iid_top #(.FIFO_DEPTH(DEPTH), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .modem_in(modem_in),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; modem_in = 4'h0; rx_valid = 1'b0; bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk8(tag, v, exp);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic set_lines(input logic [3:0] v);
    @(negedge clk);
    modem_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk1("R2 irq low after reset", irq, 1'b0);
    rd_chk("R1 idle code", 4'd2, 8'h01);
    rd_chk("R7 idle line status", 4'd5, 8'h60);
    rd_chk("R3 enable reset", 4'd1, 8'h00);
    rd_chk("R8 empty data read", 4'd0, 8'hFF);
    wr(4'd3, 8'h80);
    rd_chk("R10 divisor low reset", 4'd0, 8'd12);
    rd_chk("R10 divisor high reset", 4'd1, 8'h00);
    wr(4'd0, 8'h34);
    chk1("R10 latch write sends nothing", tx_valid, 1'b0);
    rd_chk("R10 divisor low written", 4'd0, 8'h34);
    wr(4'd3, 8'h03);
    rd_chk("R12 line control readback", 4'd3, 8'h03);
    rd_chk("R10 enable visible again", 4'd1, 8'h00);
  endtask

  task automatic t_enable_mask();
    do_reset();
    wr(4'd1, 8'hFF);
    rd_chk("R3 upper enable bits dropped", 4'd1, 8'h0F);
    chk1("R2 enabled but nothing pending", irq, 1'b0);
  endtask

  task automatic t_tx_pending();
    do_reset();
    wr(4'd0, 8'h5A);
    chk1("R4 tx strobe", tx_valid, 1'b1);
    chk8("R4 tx byte", tx_byte, 8'h5A);
    chk1("R2 masked tx gives no irq", irq, 1'b0);
    wr(4'd1, 8'h02);
    chk1("R4 pending flag is sticky", irq, 1'b1);
    rd_chk("R1 tx code", 4'd2, 8'h02);
    chk1("R5 irq drops after tx report", irq, 1'b0);
    rd_chk("R5 flag cleared", 4'd2, 8'h01);
  endtask

  task automatic t_rx_basic();
    do_reset();
    wr(4'd1, 8'h01);
    push(8'hA5);
    chk1("R2 irq on receive", irq, 1'b1);
    rd_chk("R1 receive code", 4'd2, 8'h0C);
    rd_chk("R7 data ready", 4'd5, 8'h61);
    rd_chk("R8 data value", 4'd0, 8'hA5);
    chk1("R2 irq after drain", irq, 1'b0);
    rd_chk("R7 data ready clears", 4'd5, 8'h60);
  endtask

  task automatic t_overrun_single();
    do_reset();
    wr(4'd1, 8'h05);
    push(8'h11);
    push(8'h22);
    rd_chk("R1 overrun ranks first", 4'd2, 8'h06);
    rd_chk("R7 overrun reported", 4'd5, 8'h63);
    rd_chk("R7 overrun cleared by read", 4'd5, 8'h61);
    rd_chk("R1 receive after overrun", 4'd2, 8'h0C);
    rd_chk("R8 first byte kept", 4'd0, 8'h11);
    rd_chk("R8 second byte dropped", 4'd0, 8'hFF);
  endtask

  task automatic t_fifo();
    do_reset();
    wr(4'd2, 8'h01);
    rd_chk("R6 fifo bits set", 4'd2, 8'hC1);
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1));
    rd_chk("R8 full fifo no overrun", 4'd5, 8'h61);
    push(8'hEE);
    rd_chk("R8 overrun past depth", 4'd5, 8'h63);
    for (int i = 0; i < DEPTH; i++) rd_chk("R8 fifo order", 4'd0, 8'(i * 3 + 1));
    rd_chk("R8 fifo empty", 4'd0, 8'hFF);
    push(8'h01); push(8'h02);
    wr(4'd2, 8'h03);
    rd_chk("R9 receive reset empties", 4'd5, 8'h60);
    push(8'h03);
    wr(4'd2, 8'h00);
    rd_chk("R9 disable empties", 4'd5, 8'h60);
    rd_chk("R6 fifo bits clear", 4'd2, 8'h01);
  endtask

  task automatic t_modem();
    do_reset();
    wr(4'd1, 8'h08);
    set_lines(4'b0101);
    chk1("R2 irq on modem change", irq, 1'b1);
    rd_chk("R1 modem code", 4'd2, 8'h00);
    rd_chk("R11 cts delta, ri rise ignored", 4'd6, 8'h51);
    chk1("R11 irq after status read", irq, 1'b0);
    rd_chk("R11 deltas cleared", 4'd6, 8'h50);
    set_lines(4'b0001);
    rd_chk("R11 ring falling edge", 4'd6, 8'h14);
    rd_chk("R11 ring delta cleared", 4'd6, 8'h10);
  endtask

  task automatic t_priority();
    do_reset();
    wr(4'd1, 8'h0B);
    wr(4'd0, 8'h77);
    push(8'h42);
    set_lines(4'b0010);
    rd_chk("R1 receive beats tx and modem", 4'd2, 8'h0C);
    rd_chk("R5 tx flag kept under receive", 4'd2, 8'h0C);
    rd_chk("R8 drain byte", 4'd0, 8'h42);
    rd_chk("R1 tx beats modem", 4'd2, 8'h02);
    rd_chk("R1 modem surfaces", 4'd2, 8'h00);
    rd_chk("R11 dsr delta", 4'd6, 8'h22);
    rd_chk("R1 all serviced", 4'd2, 8'h01);
    chk1("R2 irq idle at end", irq, 1'b0);
  endtask

  task automatic t_misc();
    do_reset();
    rd_chk("R12 unmapped offset", 4'd9, 8'hFF);
    wr(4'd5, 8'hFF);
    rd_chk("R7 line status write ignored", 4'd5, 8'h60);
    wr(4'd6, 8'hFF);
    rd_chk("R11 modem status write ignored", 4'd6, 8'h00);
    wr(4'd7, 8'h9C);
    rd_chk("R12 scratch", 4'd7, 8'h9C);
    wr(4'd4, 8'hFF);
    rd_chk("R12 modem control keeps 5 bits", 4'd4, 8'h1F);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset_state();
    t_enable_mask();
    t_tx_pending();
    t_rx_basic();
    t_overrun_single();
    t_fifo();
    t_modem();
    t_priority();
    t_misc();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule